// File: doc/BRIEF.md
# Gate Driver Fault Sequencer

This block is the clocked control core of a power-switch gate driver. It takes an active-low drive command, an enable and four single-bit status flags that upstream comparators have already digitized: supply above the turn-on level, supply below the turn-off level, over-temperature and desaturation. It produces two mutually exclusive gate enables, one for the pull-up stage and one for the pull-down stage, and an active-low fault line back to the system controller.

Supply loss and over-temperature are handled as staged shutdowns. The fault line is reported first. The gate then keeps following the command for a grace interval, which gives the controller time to sequence an orderly stop. After the grace interval the gate is forced off. Desaturation is handled differently: once the flag has been present for a short filter time while the gate is on, the gate is forced off and the fault is raised together, with no grace interval. All three intervals are parameters counted in clock cycles. The default grace interval is 3000 cycles, which is 12 µs at 250 MHz.

The undervoltage lock uses two flags to give hysteresis. The lock is set by the below-off-threshold flag and is released only by the above-on-threshold flag. Out of reset the lock is already set, so the driver starts in the shut-off state.

Top module: `gate_fault_seq`

## Requirements
- R1: During and after reset, and until `sup_on` is seen high with `sup_low` low, `gate_hi`=0, `gate_lo`=1 and `fault_n`=0, whatever the command. Within 3 cycles of `sup_on` rising, the driver follows the command and `fault_n`=1.
- R2: In normal operation the drive is inverting. One cycle after `cmd_n`=0 (with `enable`=1), `gate_hi`=1 and `gate_lo`=0. One cycle after `cmd_n`=1, `gate_hi`=0 and `gate_lo`=1.
- R3: One cycle after `enable` goes low, `gate_hi`=0 and `gate_lo`=1. While no fault is present, `fault_n` stays 1 in this case, whatever `cmd_n` is.
- R4: When `sup_low` is sampled high in normal operation, `fault_n` falls REPORT_CYC to REPORT_CYC+3 cycles later. The gate keeps following the command until it is forced off GRACE_CYC-1 to GRACE_CYC+1 cycles after `fault_n` fell.
- R5: After an undervoltage shutdown, `sup_low` going low by itself does not restart the driver. Only `sup_on`=1 with `sup_low`=0 releases the lock.
- R6: When `hot`=1 in normal operation, the same staged sequence and delays as R4 apply. Once the sequence is complete, the driver resumes within 3 cycles of `hot` returning to 0.
- R7: When `desat` is held high for DSAT_CYC consecutive cycles while `gate_hi`=1, the gate goes off and `fault_n` goes low DSAT_CYC to DSAT_CYC+1 cycles after `desat` rose. A `desat` pulse shorter than DSAT_CYC-1 cycles has no effect on any output.
- R8: A desaturation fault stays latched, with the gate off and `fault_n`=0, even after `desat` clears, for as long as `cmd_n`=0. The latch clears once `cmd_n`=1 and `desat`=0.
- R9: `gate_hi` and `gate_lo` are never both 1 and never both 0.
- R10: The priority order is undervoltage, then over-temperature, then desaturation, then enable, then command. A staged fault keeps `fault_n`=0 when `enable` is low, and keeps the gate off whatever `cmd_n` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_n | input | 1 | Active-low drive command (0 = gate on) |
| enable | input | 1 | Drive enable; low forces the gate off |
| sup_on | input | 1 | Supply is above the turn-on threshold |
| sup_low | input | 1 | Supply is below the turn-off threshold |
| hot | input | 1 | Over-temperature flag |
| desat | input | 1 | Desaturation comparator flag |
| gate_hi | output | 1 | Pull-up stage enable (registered) |
| gate_lo | output | 1 | Pull-down stage enable (registered) |
| fault_n | output | 1 | Active-low fault report (registered) |

## Verification
The hardest situation to reach is the grace window. In that window the fault is already reported but the gate is still on under command. The bench holds `cmd_n` low through the whole staged sequence and counts cycles from `fault_n` falling to `gate_hi` falling. It uses the same measurement to expose the latched desaturation state: the command stays on after `desat` clears, so the bench can see that the latch holds. The hysteresis lock is exercised by removing `sup_low` without raising `sup_on` and confirming that the driver stays off.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
  typedef enum logic [1:0] {
    SQ_RUN    = 2'd0,
    SQ_REPORT = 2'd1,
    SQ_GRACE  = 2'd2,
    SQ_OFF    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/gfs_uv_lock.sv
module gfs_uv_lock (
  input  logic clk,
  input  logic rst,
  input  logic sup_on,
  input  logic sup_low,
  output logic lock_q
);
  // Hysteresis: the low flag sets the lock, only the on flag releases it.
  always_ff @(posedge clk) begin
    if (rst)                    lock_q <= 1'b1;
    else if (sup_on && !sup_low) lock_q <= 1'b0;
    else if (sup_low)           lock_q <= 1'b1;
  end
endmodule

// File: rtl/gfs_staged_seq.sv
module gfs_staged_seq
  import gfs_pkg::*;
#(
  parameter int REPORT_CYC = 16,
  parameter int GRACE_CYC  = 3000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cause,
  output seq_state_t state_q,
  output logic       off_nx,
  output logic       flt_nx
);
  localparam int MAXC = (REPORT_CYC > GRACE_CYC) ? REPORT_CYC : GRACE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] REP_LAST = CW'(REPORT_CYC - 1);
  localparam logic [CW-1:0] GRC_LAST = CW'(GRACE_CYC - 1);

  seq_state_t    state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SQ_RUN: begin
        if (cause) begin
          state_d = SQ_REPORT;
          cnt_d   = '0;
        end
      end
      SQ_REPORT: begin
        if (cnt_q == REP_LAST) begin
          state_d = SQ_GRACE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_GRACE: begin
        if (cnt_q == GRC_LAST) begin
          state_d = SQ_OFF;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_OFF: begin
        if (!cause) state_d = SQ_RUN;
      end
      default: state_d = SQ_OFF;
    endcase
  end

  assign off_nx = (state_d == SQ_OFF);
  assign flt_nx = (state_d == SQ_GRACE) || (state_d == SQ_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/gfs_desat_guard.sv
module gfs_desat_guard #(
  parameter int DSAT_CYC = 55
) (
  input  logic clk,
  input  logic rst,
  input  logic desat,
  input  logic gate_on,
  input  logic cmd_n,
  output logic latch_q,
  output logic latch_nx
);
  localparam int CW = $clog2(DSAT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DSAT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    latch_nx = latch_q;
    cnt_d    = '0;
    if (latch_q) begin
      if (cmd_n && !desat) latch_nx = 1'b0;
    end else if (desat && gate_on) begin
      if (cnt_q == LAST) latch_nx = 1'b1;
      else               cnt_d    = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      latch_q <= latch_nx;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/gate_fault_seq.sv
module gate_fault_seq
  import gfs_pkg::*;
#(
  parameter int REPORT_CYC = 16,
  parameter int GRACE_CYC  = 3000,
  parameter int DSAT_CYC   = 55
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_n,
  input  logic enable,
  input  logic sup_on,
  input  logic sup_low,
  input  logic hot,
  input  logic desat,
  output logic gate_hi,
  output logic gate_lo,
  output logic fault_n
);
  seq_state_t seq_q;
  logic uv_lock, seq_off_nx, seq_flt_nx, dlatch, dlatch_nx;
  logic st_off, drive_nx, fault_nx;

  gfs_uv_lock u_uv (
    .clk(clk), .rst(rst), .sup_on(sup_on), .sup_low(sup_low), .lock_q(uv_lock)
  );

  gfs_staged_seq #(.REPORT_CYC(REPORT_CYC), .GRACE_CYC(GRACE_CYC)) u_seq (
    .clk(clk), .rst(rst), .cause(uv_lock | hot),
    .state_q(seq_q), .off_nx(seq_off_nx), .flt_nx(seq_flt_nx)
  );

  gfs_desat_guard #(.DSAT_CYC(DSAT_CYC)) u_dsat (
    .clk(clk), .rst(rst), .desat(desat), .gate_on(gate_hi), .cmd_n(cmd_n),
    .latch_q(dlatch), .latch_nx(dlatch_nx)
  );

  assign st_off   = (seq_q == SQ_OFF);
  // Priority: staged shutdown, then desat latch, then enable, then command.
  assign drive_nx = !seq_off_nx && !dlatch_nx && enable && !cmd_n;
  assign fault_nx = seq_flt_nx || dlatch_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b1;
      fault_n <= 1'b0;
    end else begin
      gate_hi <= drive_nx;
      gate_lo <= !drive_nx;
      fault_n <= !fault_nx;
    end
  end
endmodule

// File: rtl/gfs_checker.sv
module gfs_checker (
  input logic clk,
  input logic rst,
  input logic cmd_n,
  input logic enable,
  input logic gate_hi,
  input logic gate_lo,
  input logic fault_n,
  input logic uv_lock,
  input logic st_off,
  input logic dlatch
);
  a_r9_complementary: assert property (@(posedge clk) disable iff (rst)
    gate_hi != gate_lo);
  a_r3_enable_forces_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !gate_hi);
  a_r2_cmd_high_off: assert property (@(posedge clk) disable iff (rst)
    cmd_n |=> !gate_hi);
  a_r5_uv_lock_holds_off: assert property (@(posedge clk) disable iff (rst)
    (st_off && uv_lock) |=> !gate_hi);
  a_r8_latch_blocks_gate: assert property (@(posedge clk) disable iff (rst)
    dlatch |-> (!gate_hi && !fault_n));
  a_r10_off_reports_fault: assert property (@(posedge clk) disable iff (rst)
    (st_off && $past(st_off)) |-> !fault_n);
endmodule

bind gate_fault_seq gfs_checker u_chk (
  .clk(clk), .rst(rst), .cmd_n(cmd_n), .enable(enable),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n),
  .uv_lock(uv_lock), .st_off(st_off), .dlatch(dlatch)
);

// File: tb/tb_gate_fault_seq.sv
`timescale 1ns/1ps
module tb_gate_fault_seq;
  localparam int R = 16;
  localparam int G = 3000;
  localparam int D = 55;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_n = 1'b1, enable = 1'b1, sup_on = 1'b0, sup_low = 1'b0;
  logic hot = 1'b0, desat = 1'b0;
  logic gate_hi, gate_lo, fault_n;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  gate_fault_seq #(.REPORT_CYC(R), .GRACE_CYC(G), .DSAT_CYC(D)) dut (
    .clk(clk), .rst(rst), .cmd_n(cmd_n), .enable(enable), .sup_on(sup_on),
    .sup_low(sup_low), .hot(hot), .desat(desat),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
  );

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag, input int hi, input int flt);
    chk(gate_hi == hi, {tag, " gate_hi"}, gate_hi, hi);
    chk(gate_lo == !hi, {tag, " gate_lo (R9)"}, gate_lo, !hi);
    chk(fault_n == flt, {tag, " fault_n"}, fault_n, flt);
  endtask

  // Steps until fault_n == v; returns cycles taken, or limit+1.
  task automatic wait_fault(input bit v, input int limit, output int n);
    n = 0;
    while (fault_n != v && n <= limit) begin step(); n++; end
  endtask

  task automatic wait_gate(input bit v, input int limit, output int n);
    n = 0;
    while (gate_hi != v && n <= limit) begin step(); n++; end
  endtask

  task automatic t_startup();
    int n;
    step(3);
    chk_outs("R1 in reset", 0, 0);
    rst = 1'b0; cmd_n = 1'b0;
    step(10);
    chk_outs("R1 no supply, command ignored", 0, 0);
    sup_on = 1'b1;
    step(3);
    chk_outs("R1 after sup_on", 1, 1);
    sup_on = 1'b0;
  endtask

  task automatic t_drive();
    cmd_n = 1'b1; step(1);
    chk_outs("R2 cmd high off", 0, 1);
    cmd_n = 1'b0; step(1);
    chk_outs("R2 cmd low on", 1, 1);
  endtask

  task automatic t_enable();
    enable = 1'b0; step(1);
    chk_outs("R3 enable low, cmd on", 0, 1);
    cmd_n = 1'b1; step(2);
    chk_outs("R3 enable low, cmd off", 0, 1);
    enable = 1'b1; cmd_n = 1'b0; step(1);
    chk_outs("R3 enable restored", 1, 1);
  endtask

  task automatic t_uv();
    int n, m;
    sup_low = 1'b1;
    wait_fault(1'b0, R + 10, n);
    chk(n >= R && n <= R + 3, "R4 uv report delay", n, R + 2);
    chk(gate_hi == 1, "R4 gate on in grace", gate_hi, 1);
    wait_gate(1'b0, G + 10, m);
    chk(m >= G - 1 && m <= G + 1, "R4 uv grace delay", m, G);
    enable = 1'b0; step(3);
    chk_outs("R10 uv overrides enable", 0, 0);
    enable = 1'b1;
    sup_low = 1'b0; step(10);
    chk_outs("R5 lock held without sup_on", 0, 0);
    sup_on = 1'b1; step(3);
    chk_outs("R5 released by sup_on", 1, 1);
    sup_on = 1'b0;
  endtask

  task automatic t_thermal();
    int n, m;
    hot = 1'b1;
    wait_fault(1'b0, R + 10, n);
    chk(n >= R && n <= R + 3, "R6 thermal report delay", n, R + 1);
    wait_gate(1'b0, G + 10, m);
    chk(m >= G - 1 && m <= G + 1, "R6 thermal grace delay", m, G);
    desat = 1'b1; step(5);
    chk_outs("R10 thermal off, desat no effect on gate", 0, 0);
    desat = 1'b0; step(5);
    chk_outs("R6 held while hot", 0, 0);
    hot = 1'b0; step(3);
    chk_outs("R6 resumes after hot clears", 1, 1);
  endtask

  task automatic t_desat();
    int n;
    desat = 1'b1; step(D - 2);
    desat = 1'b0; step(3);
    chk_outs("R7 short desat pulse ignored", 1, 1);
    desat = 1'b1;
    wait_gate(1'b0, D + 10, n);
    chk(n >= D && n <= D + 1, "R7 desat shutdown delay", n, D);
    chk(fault_n == 0, "R7 desat fault low", fault_n, 0);
    desat = 1'b0; step(5);
    chk_outs("R8 latched while cmd on", 0, 0);
    cmd_n = 1'b1; step(2);
    chk_outs("R8 cleared by cmd off", 0, 1);
    cmd_n = 1'b0; step(1);
    chk_outs("R8 drive resumes", 1, 1);
  endtask

  initial begin
    t_startup();
    t_drive();
    t_enable();
    t_uv();
    t_thermal();
    t_desat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule